// File: doc/BRIEF.md
# Cascadable Decade Counter Stage

This block is one decimal digit of a counter. A 4-bit register runs through the codes 0 to 9. It advances by one on each rising clock edge while the count enable is high, and it returns to 0 after 9. A clear input is asynchronous and active high. It overrides everything else and empties the stage at once, without waiting for a clock edge. The same clear serves as the power-up or global initialisation of the register.

Two decode outputs let stages be chained. The terminal flag depends only on the stored digit and is high at 9. The cascade output is the terminal flag gated by the stage's own enable. To build a multi-digit counter, feed each stage's cascade output into the enable of the next, more significant stage, and share the clock and clear among all stages. A digit then steps only when every less significant digit sits at 9 and the chain is enabled.

A 4-bit register has six codes that are not decimal. The stage leaves any of them along a fixed path and reaches a decimal digit within two enabled edges.

Top module: `dec_stage`

## Requirements
- R1: While `clr_i` is high, `digit_o`, `term_o` and `cascade_o` are 0 with no clock edge needed, and clock edges are ignored. Applying the clear is also how the register is initialised at power-up.
- R2: On a rising `clk_i` edge with `cnt_en_i` high and a digit from 0 to 8, the digit increases by one.
- R3: On a rising `clk_i` edge with `cnt_en_i` low, the digit keeps its value. This includes the illegal codes.
- R4: On a rising edge with `cnt_en_i` high and the digit at 9 (binary 1001), the digit becomes 0.
- R5: `term_o` is 1 exactly when `digit_o` is 4'b1001, whatever `cnt_en_i` is. It is 0 for every other code, including illegal codes such as 4'b1011 and 4'b1101.
- R6: `cascade_o` equals `term_o` AND `cnt_en_i`.
- R7: On an enabled edge the illegal codes step as follows: 1010→1011, 1100→1101 and 1110→1111, then 1011→0110, 1101→0100 and 1111→0010. A decimal digit is therefore reached within two enabled edges.
- R8: When two stages share clock and clear, and the low stage's `cascade_o` drives the high stage's `cnt_en_i`, the pair counts 00 to 99 on consecutive enabled edges and then wraps to 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the digit changes on its rising edge |
| clr_i | input | 1 | Asynchronous clear, active high, highest priority |
| cnt_en_i | input | 1 | Count enable |
| digit_o | output | 4 | Current digit, binary |
| term_o | output | 1 | High while the digit is 9 |
| cascade_o | output | 1 | Enable for the next stage: term_o AND cnt_en_i |

## Verification
The clocked properties assume that `cnt_en_i` is stable around each rising edge and that the digit changes only through the clock or the clear. The bench therefore changes the enable only on falling edges. It puts the stage into the illegal codes only while the clear is held high across a rising edge, and it drops the clear before the next edge, so no property attempt ever spans such an injection. Clear pulses that start in the middle of a cycle also stay high across at least one rising edge, so every attempt they interrupt is disabled.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int DIGIT_W = 4;
  localparam int LAST_DIGIT = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t TERM_CODE = digit_t'(LAST_DIGIT);
endpackage

// File: rtl/dec_next_state.sv
module dec_next_state
  import dec_pkg::*;
(
  input  digit_t cur_i,
  output digit_t nxt_o
);
  always_comb begin
    unique case (cur_i)
      4'd9:    nxt_o = 4'd0;
      4'd10:   nxt_o = 4'd11;
      4'd11:   nxt_o = 4'd6;
      4'd12:   nxt_o = 4'd13;
      4'd13:   nxt_o = 4'd4;
      4'd14:   nxt_o = 4'd15;
      4'd15:   nxt_o = 4'd2;
      default: nxt_o = cur_i + digit_t'(1);
    endcase
  end
endmodule

// File: rtl/dec_term_decode.sv
module dec_term_decode
  import dec_pkg::*;
(
  input  digit_t cur_i,
  input  logic   en_i,
  output logic   term_o,
  output logic   cascade_o
);
  assign term_o    = (cur_i == TERM_CODE);
  assign cascade_o = term_o & en_i;
endmodule

// File: rtl/dec_stage.sv
module dec_stage
  import dec_pkg::*;
(
  input  logic               clk_i,
  input  logic               clr_i,
  input  logic               cnt_en_i,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               term_o,
  output logic               cascade_o
);
  digit_t cnt_q;
  digit_t cnt_nxt;

  dec_next_state u_next (
    .cur_i (cnt_q),
    .nxt_o (cnt_nxt)
  );

  always_ff @(posedge clk_i or posedge clr_i) begin
    if (clr_i)         cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_nxt;
  end

  dec_term_decode u_dec (
    .cur_i     (cnt_q),
    .en_i      (cnt_en_i),
    .term_o    (term_o),
    .cascade_o (cascade_o)
  );

  assign digit_o = cnt_q;

  // R2
  inc_step_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (cnt_en_i && cnt_q < TERM_CODE) |=> (cnt_q == $past(cnt_q) + digit_t'(1)));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    !cnt_en_i |=> $stable(cnt_q));
  // R4
  wrap_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (term_o && cnt_en_i) |=> (cnt_q == '0));
  // R6
  cascade_gate_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    cascade_o |-> (cnt_en_i && cnt_q == TERM_CODE));
  // R7
  illegal_first_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (cnt_en_i && cnt_q > TERM_CODE && !cnt_q[0]) |=> (cnt_q == $past(cnt_q) + digit_t'(1)));
  // R7
  illegal_exit_chk: assert property (@(posedge clk_i) disable iff (clr_i)
    (cnt_en_i && cnt_q > TERM_CODE && cnt_q[0]) |=> (cnt_q < TERM_CODE));
endmodule

// File: tb/test_dec_stage.sv
module test_dec_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic clr = 1'b1;
  logic en  = 1'b0;
  logic [3:0] digit;
  logic term, cascade;

  logic ch_en = 1'b0;
  logic [3:0] lo_d, hi_d;
  logic lo_t, lo_c, hi_t, hi_c;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dec_stage i_dec_stage (
    .clk_i(clk), .clr_i(clr), .cnt_en_i(en),
    .digit_o(digit), .term_o(term), .cascade_o(cascade));

  dec_stage u_lo (
    .clk_i(clk), .clr_i(clr), .cnt_en_i(ch_en),
    .digit_o(lo_d), .term_o(lo_t), .cascade_o(lo_c));

  dec_stage u_hi (
    .clk_i(clk), .clr_i(clr), .cnt_en_i(lo_c),
    .digit_o(hi_d), .term_o(hi_t), .cascade_o(hi_c));

  typedef struct packed {
    logic [3:0] d;
    logic       t;
    logic       c;
  } exp_t;

  exp_t sb_q[$];
  string sb_tag[$];
  logic [3:0] model = 4'd0;

  function automatic logic [3:0] ref_next(input logic [3:0] v);
    case (v)
      4'd9:  return 4'd0;
      4'd10: return 4'd11;
      4'd11: return 4'd6;
      4'd12: return 4'd13;
      4'd13: return 4'd4;
      4'd14: return 4'd15;
      4'd15: return 4'd2;
      default: return v + 4'd1;
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // driver: one edge with the given enable, expected result pushed to scoreboard
  task automatic step(input logic e, input string req);
    exp_t x;
    @(negedge clk);
    en = e;
    if (e) model = ref_next(model);
    x.d = model;
    x.t = (model == 4'd9);
    x.c = x.t & e;
    sb_q.push_back(x);
    sb_tag.push_back(req);
    @(posedge clk);
    #3;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t x;
        string tg;
        x = sb_q.pop_front();
        tg = sb_tag.pop_front();
        check({tg, " digit"},   digit,   x.d);
        check({tg, " term"},    term,    x.t);
        check({tg, " cascade"}, cascade, x.c);
      end
    end
  end

  task automatic inject(input logic [3:0] code);
    @(negedge clk);
    en  = 1'b0;
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    force i_dec_stage.cnt_q = code;
    #1 release i_dec_stage.cnt_q;
    #1 clr = 1'b0;
    model = code;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    // R1 reset state
    check("R1 reset digit", digit, 0);
    check("R1 reset term", term, 0);
    check("R1 reset cascade", cascade, 0);
    @(negedge clk);
    clr = 1'b0;
    model = 4'd0;

    // R2 / R4 / R5 / R6: full decade with enable high, then wrap
    for (int i = 0; i < 12; i++) step(1'b1, "R2 R4 count");
    // R3: hold with enable low (including at 9, R5/R6)
    for (int i = 0; i < 7; i++) step(1'b1, "R2 approach");
    step(1'b0, "R3 hold at 9 R5 R6");
    step(1'b0, "R3 hold at 9 R5 R6");
    step(1'b1, "R4 wrap after hold");
    // R6: alternating enable
    for (int i = 0; i < 20; i++) step(i[0] ^ i[2], "R6 mixed enable");

    // R1: clear mid-cycle, effective with no clock edge
    @(negedge clk);
    en = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    clr = 1'b1;
    #1;
    check("R1 async digit", digit, 0);
    check("R1 async term", term, 0);
    check("R1 async cascade", cascade, 0);
    repeat (3) @(posedge clk);
    #2;
    check("R1 edges ignored", digit, 0);
    @(negedge clk);
    clr = 1'b0;
    en = 1'b0;
    model = 4'd0;

    // R7 / R5 / R3: every illegal code
    for (int c = 10; c < 16; c++) begin
      inject(4'(c));
      #1;
      check("R5 illegal term low", term, 0);
      check("R6 illegal cascade low", cascade, 0);
      step(1'b0, "R3 illegal hold");
      step(1'b1, "R7 recovery step");
      if (c[0] == 1'b0) step(1'b1, "R7 recovery step2");
      check("R7 decimal within two", (digit <= 4'd9) ? 1 : 0, 1);
    end

    // R8: two-stage chain
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr = 1'b0;
    ch_en = 1'b1;
    for (int k = 1; k <= 101; k++) begin
      @(posedge clk);
      #2;
      check("R8 chain value", hi_d * 10 + lo_d, k % 100);
      if (k % 100 == 99) check("R8 chain top cascade", hi_c, 1);
    end
    @(negedge clk);
    ch_en = 1'b0;
    @(posedge clk);
    #2;
    check("R8 chain hold", hi_d * 10 + lo_d, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule